// File: doc/BRIEF.md
# Brushed DC Motor Bridge Supervisor

This block is the digital core of a full-bridge brushed DC motor driver. It turns a direction input and a PWM input into four gate-enable signals, one for each transistor of the two bridge legs. A control register can switch the block to half-bridge operation, where each input steers one leg on its own. The same register holds copies of both control inputs. Software can select these copies in place of the pins, so the motor can still be driven if a pin connection is lost.

Nine fault flags arrive from the analog sensing. Each one is latched into a sticky status register that software clears by writing ones. A mask register decides which latched faults pull the active-low fault output. While that output is low, or while the enable pin is low, every gate is turned off and the bridge is reported as high impedance. When the conducting side of a leg reverses, the block holds both transistors of that leg off for a programmable dead-time.

Software reaches the registers through a single-cycle parallel port. The slew-rate and current-limit fields are passed straight out to the analog section.

Top module: `mdrv_fault_sup`

## Requirements
- R1: During and after reset every gate output is 0 and `fault_n` is 1. The control register (address 0) reads 0, the status register (address 1) reads 0 and the mask register (address 2) reads 0x1FF.
- R2: In full-bridge mode (control bit 0 = 0) the gate bits are [0] leg A high, [1] leg A low, [2] leg B high and [3] leg B low. With direction 1, leg A high follows PWM and leg B low is on. With direction 0, leg B high follows PWM and leg A low is on. Gates update one clock after the inputs.
- R3: In half-bridge mode (control bit 0 = 1), leg A is driven by the direction input and leg B by the PWM input. An input at 1 turns on that leg's high side and an input at 0 turns on its low side.
- R4: With control bit 1 set, control bit 2 replaces the direction pin and control bit 3 replaces the PWM pin, and both pins are ignored.
- R5: Control bits [11:8] set the dead-time D. When a leg must turn on the side opposite to the one it last drove and D is not 0, both gates of that leg stay off for exactly D clocks before the new side turns on.
- R6: A fault flag that is high at a clock edge sets its status bit at that edge. The bit stays set after the flag falls. A flag that is still high overrides a clear aimed at the same bit.
- R7: Writing to address 1 clears each status bit whose data bit is 1. Writing a 0 leaves that bit unchanged.
- R8: `fault_n` is 0 exactly when a set status bit has its mask bit (address 2) set. Status bits whose mask bit is clear do not affect `fault_n` or the gates.
- R9: While `fault_n` is 0, all gates are 0 and `bridge_hiz` is 1 in the same cycle. After the fault is cleared, drive resumes with no dead-time penalty.
- R10: While `drv_en` is 0, all gates are 0 and `bridge_hiz` is 1 in the same cycle.
- R11: Control bits [5:4] appear on `cfg_slew` and control bits [7:6] appear on `cfg_ocl`. `cfg_half` reflects control bit 0.
- R12: The two gates of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Enable pin; 0 turns the bridge off |
| in_dir | input | 1 | Direction pin (leg A input in half-bridge mode) |
| in_pwm | input | 1 | PWM pin (leg B input in half-bridge mode) |
| flt_raw | input | 9 | Raw fault flags: short, over-volt, under-volt, open load, pump under-volt, current limit, frame error, thermal warning, thermal shutdown (bits 0..8) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| fault_n | output | 1 | Active-low masked fault indication |
| bridge_hiz | output | 1 | 1 when the bridge is forced to high impedance |
| gate_on | output | 4 | Gate enables {B low, B high, A low, A high} |
| cfg_half | output | 1 | Half-bridge mode selected |
| cfg_slew | output | 2 | Slew-rate setting |
| cfg_ocl | output | 2 | Overcurrent-limit setting |

## Verification
A stuck or lost status bit appears at `fault_n` and on the gates in the same cycle the bit should change. Such a bit is also visible on the next read of address 1. A wrong leg state, such as a dead-time counter that is off by one or a side memory that is not cleared, shows up as gates that turn on one clock too early or too late after a direction reversal. It can also show up as a needless off period after a fault is released. Steering faults appear on `gate_on` one clock after the offending input.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
   localparam int N_FLT = 9;
   localparam int CB_HALF = 0;
   localparam int CB_MIRR = 1;
   localparam int CB_MDIR = 2;
   localparam int CB_MPWM = 3;
   localparam int CB_FLD0 = 4;
   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_STAT = 2'd1;
   localparam logic [1:0] ADR_MASK = 2'd2;
   typedef struct packed {
      logic hs;
      logic ls;
   } leg_req_t;
endpackage

// File: rtl/mdrv_regs.sv
module mdrv_regs
   import mdrv_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   parameter int SLEW_W = 2,
   parameter int OCL_W  = 2,
   parameter int DT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_FLT-1:0]  raw,
   output logic [N_FLT-1:0]  status,
   output logic [N_FLT-1:0]  mask,
   output logic              fault_n,
   output logic              half,
   output logic              mirr,
   output logic              mdir,
   output logic              mpwm,
   output logic [SLEW_W-1:0] slew,
   output logic [OCL_W-1:0]  ocl,
   output logic [DT_W-1:0]   dt
);
   localparam int CTRL_W = CB_FLD0 + SLEW_W + OCL_W + DT_W;
   localparam int OCL_LO = CB_FLD0 + SLEW_W;
   localparam int DT_LO  = OCL_LO + OCL_W;

   logic [CTRL_W-1:0] ctrl_q;
   logic [N_FLT-1:0]  stat_q, mask_q, clr;
   logic wr_ctrl, wr_stat, wr_mask;
   logic wdata_unused;

   assign wdata_unused = ^wdata;
   assign wr_ctrl = wr && (addr == ADDR_W'(ADR_CTRL));
   assign wr_stat = wr && (addr == ADDR_W'(ADR_STAT));
   assign wr_mask = wr && (addr == ADDR_W'(ADR_MASK));
   assign clr     = wr_stat ? wdata[N_FLT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         if (wr_mask) mask_q <= wdata[N_FLT-1:0];
         stat_q <= (stat_q & ~clr) | raw;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_CTRL))      rdata[CTRL_W-1:0] = ctrl_q;
      else if (addr == ADDR_W'(ADR_STAT)) rdata[N_FLT-1:0]  = stat_q;
      else if (addr == ADDR_W'(ADR_MASK)) rdata[N_FLT-1:0]  = mask_q;
   end

   assign status  = stat_q;
   assign mask    = mask_q;
   assign fault_n = ~|(stat_q & mask_q);
   assign half    = ctrl_q[CB_HALF];
   assign mirr    = ctrl_q[CB_MIRR];
   assign mdir    = ctrl_q[CB_MDIR];
   assign mpwm    = ctrl_q[CB_MPWM];
   assign slew    = ctrl_q[CB_FLD0 +: SLEW_W];
   assign ocl     = ctrl_q[OCL_LO +: OCL_W];
   assign dt      = ctrl_q[DT_LO +: DT_W];
endmodule

// File: rtl/mdrv_steer.sv
module mdrv_steer
   import mdrv_pkg::*;
(
   input  logic     half,
   input  logic     mirr,
   input  logic     mdir,
   input  logic     mpwm,
   input  logic     pin_dir,
   input  logic     pin_pwm,
   output leg_req_t req_a,
   output leg_req_t req_b
);
   logic d, p;
   assign d = mirr ? mdir : pin_dir;
   assign p = mirr ? mpwm : pin_pwm;

   always_comb begin
      if (half) begin
         req_a = '{hs: d, ls: ~d};
         req_b = '{hs: p, ls: ~p};
      end else if (d) begin
         req_a = '{hs: p, ls: 1'b0};
         req_b = '{hs: 1'b0, ls: 1'b1};
      end else begin
         req_a = '{hs: 1'b0, ls: 1'b1};
         req_b = '{hs: p, ls: 1'b0};
      end
   end
endmodule

// File: rtl/mdrv_leg.sv
module mdrv_leg
   import mdrv_pkg::*;
#(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            force_off,
   input  logic [DT_W-1:0] dt,
   input  leg_req_t        req,
   output leg_req_t        gate
);
   logic            side_vld, side_hs;
   logic [DT_W-1:0] cnt;
   logic            opp;

   assign opp = side_vld && ((req.hs && !side_hs) || (req.ls && side_hs));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate     <= '0;
         side_vld <= 1'b0;
         side_hs  <= 1'b0;
         cnt      <= '0;
      end else if (force_off) begin
         gate     <= '0;
         side_vld <= 1'b0;
         cnt      <= '0;
      end else if (cnt != '0) begin
         gate <= '0;
         cnt  <= cnt - 1'b1;
      end else if (opp && dt != '0) begin
         gate     <= '0;
         cnt      <= dt - 1'b1;
         side_vld <= 1'b0;
      end else begin
         gate <= req;
         if (req.hs || req.ls) begin
            side_vld <= 1'b1;
            side_hs  <= req.hs;
         end
      end
   end
endmodule

// File: rtl/mdrv_fault_sup.sv
module mdrv_fault_sup
   import mdrv_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   parameter int SLEW_W = 2,
   parameter int OCL_W  = 2,
   parameter int DT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_en,
   input  logic              in_dir,
   input  logic              in_pwm,
   input  logic [N_FLT-1:0]  flt_raw,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              fault_n,
   output logic              bridge_hiz,
   output logic [3:0]        gate_on,
   output logic              cfg_half,
   output logic [SLEW_W-1:0] cfg_slew,
   output logic [OCL_W-1:0]  cfg_ocl
);
   localparam int CTRL_W = CB_FLD0 + SLEW_W + OCL_W + DT_W;
   localparam int N_LEG  = 2;

   if (CTRL_W > DATA_W) begin : g_bad_ctrl_w
      $error("control fields exceed DATA_W");
   end
   if (N_FLT > DATA_W) begin : g_bad_flt_w
      $error("fault vector exceeds DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W must be at least 2");
   end
   if (DT_W < 1) begin : g_bad_dt_w
      $error("DT_W must be at least 1");
   end

   logic [N_FLT-1:0] status_w, mask_w;
   logic [DT_W-1:0]  dt_w;
   logic             mirr, mdir, mpwm;
   leg_req_t         req [N_LEG];
   leg_req_t         leg_g [N_LEG];
   logic [3:0]       raw_gate;

   mdrv_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLEW_W(SLEW_W),
      .OCL_W(OCL_W), .DT_W(DT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .raw(flt_raw),
      .status(status_w), .mask(mask_w), .fault_n(fault_n),
      .half(cfg_half), .mirr(mirr), .mdir(mdir), .mpwm(mpwm),
      .slew(cfg_slew), .ocl(cfg_ocl), .dt(dt_w)
   );

   mdrv_steer u_steer (
      .half(cfg_half), .mirr(mirr), .mdir(mdir), .mpwm(mpwm),
      .pin_dir(in_dir), .pin_pwm(in_pwm),
      .req_a(req[0]), .req_b(req[1])
   );

   assign bridge_hiz = ~drv_en | ~fault_n;

   for (genvar i = 0; i < N_LEG; i++) begin : g_leg
      mdrv_leg #(.DT_W(DT_W)) u_leg (
         .clk(clk), .rst_n(rst_n), .force_off(bridge_hiz),
         .dt(dt_w), .req(req[i]), .gate(leg_g[i])
      );
      assign raw_gate[2*i]   = leg_g[i].hs;
      assign raw_gate[2*i+1] = leg_g[i].ls;
   end

   assign gate_on = bridge_hiz ? 4'b0000 : raw_gate;
endmodule

// File: rtl/mdrv_fault_sup_chk.sv
module mdrv_fault_sup_chk
   import mdrv_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DT_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              drv_en,
   input logic [N_FLT-1:0]  flt_raw,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              fault_n,
   input logic [3:0]        gate_on,
   input logic [N_FLT-1:0]  status_w,
   input logic [N_FLT-1:0]  mask_w,
   input logic [DT_W-1:0]   dt_w
);
   logic wr_stat, wr_mask;
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(ADR_STAT));
   assign wr_mask = reg_wr && (reg_addr == ADDR_W'(ADR_MASK));

   p_raw_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_raw != '0) |=> ((status_w & $past(flt_raw)) == $past(flt_raw)));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((status_w & $past(status_w)) == $past(status_w)));

   p_mask_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((flt_raw & mask_w) != '0) && !wr_mask) |=> !fault_n);

   p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> (gate_on == 4'b0000));

   p_en_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> (gate_on == 4'b0000));

   p_leg_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_on[0] && gate_on[1]) && !(gate_on[2] && gate_on[3]));

   p_dead_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on[0] && dt_w != '0) |=> !gate_on[1]);

   p_dead_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on[3] && dt_w != '0) |=> !gate_on[2]);
endmodule

bind mdrv_fault_sup mdrv_fault_sup_chk #(.ADDR_W(ADDR_W), .DT_W(DT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .flt_raw(flt_raw),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .fault_n(fault_n),
   .gate_on(gate_on), .status_w(status_w), .mask_w(mask_w), .dt_w(dt_w)
);

// File: tb/mdrv_fault_sup_test.sv
module mdrv_fault_sup_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        drv_en = 1'b1;
   logic        in_dir = 1'b0;
   logic        in_pwm = 1'b0;
   logic [8:0]  flt_raw = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        fault_n, bridge_hiz, cfg_half;
   logic [3:0]  gate_on;
   logic [1:0]  cfg_slew, cfg_ocl;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mdrv_fault_sup uut (
      .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .in_dir(in_dir),
      .in_pwm(in_pwm), .flt_raw(flt_raw), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fault_n(fault_n), .bridge_hiz(bridge_hiz), .gate_on(gate_on),
      .cfg_half(cfg_half), .cfg_slew(cfg_slew), .cfg_ocl(cfg_ocl)
   );

   // {half, mirror, mdir, mpwm, pin_dir, pin_pwm, expected gate[3:0]}
   localparam logic [9:0] VEC [12] = '{
      {6'b000011, 4'b1001}, {6'b000010, 4'b1000},
      {6'b000001, 4'b0110}, {6'b000000, 4'b0010},
      {6'b011100, 4'b1001}, {6'b010111, 4'b0110},
      {6'b011001, 4'b1000},
      {6'b100011, 4'b0101}, {6'b100010, 4'b1001},
      {6'b100001, 4'b0110}, {6'b100000, 4'b1010},
      {6'b110110, 4'b0110}
   };

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      tick(2);
      // R1 reset state
      chk("R1 gates", {12'h0, gate_on}, 16'h0);
      chk("R1 fault_n", {15'h0, fault_n}, 16'h1);
      rd(2'd0, rv); chk("R1 ctrl", rv, 16'h0000);
      rd(2'd1, rv); chk("R1 status", rv, 16'h0000);
      rd(2'd2, rv); chk("R1 mask", rv, 16'h01FF);
      tick(1);
      rst_n = 1'b1;
      tick(2);

      // steering table, dead-time 0
      for (int i = 0; i < 12; i++) begin
         in_dir = VEC[i][5];
         in_pwm = VEC[i][4];
         wr(2'd0, {12'h0, VEC[i][6], VEC[i][7], VEC[i][8], VEC[i][9]});
         tick(1);
         chk(VEC[i][9] ? "R3 half steer" : (VEC[i][8] ? "R4 mirror steer" : "R2 full steer"),
             {12'h0, gate_on}, {12'h0, VEC[i][3:0]});
      end

      // R11 config fields
      wr(2'd0, 16'h0061);
      chk("R11 half", {15'h0, cfg_half}, 16'h1);
      chk("R11 slew", {14'h0, cfg_slew}, 16'h2);
      chk("R11 ocl", {14'h0, cfg_ocl}, 16'h1);
      rd(2'd0, rv); chk("R11 ctrl readback", rv, 16'h0061);

      // R5 dead-time 3, full bridge forward; R12 legs off during gap
      in_dir = 1'b1; in_pwm = 1'b1;
      wr(2'd0, 16'h0300);
      tick(5);
      chk("R5 forward steady", {12'h0, gate_on}, 16'h0009);
      in_dir = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick(1);
         chk("R5 R12 gap reverse", {12'h0, gate_on}, 16'h0000);
      end
      tick(1);
      chk("R5 reverse on", {12'h0, gate_on}, 16'h0006);
      in_dir = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick(1);
         chk("R5 R12 gap forward", {12'h0, gate_on}, 16'h0000);
      end
      tick(1);
      chk("R5 forward on", {12'h0, gate_on}, 16'h0009);

      // R6 R9 fault pulse, sticky, gates off same cycle
      flt_raw = 9'h001;
      tick(1);
      flt_raw = 9'h000;
      chk("R9 fault_n low", {15'h0, fault_n}, 16'h0);
      chk("R9 hiz", {15'h0, bridge_hiz}, 16'h1);
      chk("R9 gates off", {12'h0, gate_on}, 16'h0);
      tick(2);
      rd(2'd1, rv); chk("R6 sticky", rv, 16'h0001);
      wr(2'd1, 16'h0000);
      rd(2'd1, rv); chk("R7 zero write keeps", rv, 16'h0001);
      wr(2'd1, 16'h0001);
      rd(2'd1, rv); chk("R7 clear", rv, 16'h0000);
      chk("R7 fault_n released", {15'h0, fault_n}, 16'h1);
      tick(1);
      chk("R9 resume no gap", {12'h0, gate_on}, 16'h0009);

      // R6 raw held beats clear
      flt_raw = 9'h100;
      tick(1);
      wr(2'd1, 16'h0100);
      rd(2'd1, rv); chk("R6 set wins", rv, 16'h0100);
      flt_raw = 9'h000;
      wr(2'd1, 16'h01FF);
      rd(2'd1, rv); chk("R7 clear after", rv, 16'h0000);
      tick(2);

      // R8 mask
      wr(2'd2, 16'h017F);
      flt_raw = 9'h080;
      tick(1);
      flt_raw = 9'h000;
      tick(1);
      rd(2'd1, rv); chk("R8 unmasked latched", rv, 16'h0080);
      chk("R8 unmasked fault_n", {15'h0, fault_n}, 16'h1);
      chk("R8 unmasked gates", {12'h0, gate_on}, 16'h0009);
      flt_raw = 9'h020;
      tick(1);
      flt_raw = 9'h000;
      chk("R8 masked fault_n", {15'h0, fault_n}, 16'h0);
      rd(2'd2, rv); chk("R8 mask readback", rv, 16'h017F);
      wr(2'd1, 16'h01FF);
      wr(2'd2, 16'h01FF);
      tick(2);
      chk("R8 recovered", {12'h0, gate_on}, 16'h0009);

      // R10 enable
      drv_en = 1'b0;
      #1;
      chk("R10 gates off", {12'h0, gate_on}, 16'h0);
      chk("R10 hiz", {15'h0, bridge_hiz}, 16'h1);
      tick(3);
      chk("R10 held off", {12'h0, gate_on}, 16'h0);
      drv_en = 1'b1;
      tick(2);
      chk("R10 resume", {12'h0, gate_on}, 16'h0009);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule